// File: doc/BRIEF.md
# Split Load Request Issuer

This block sends loads to a data cache port. An aligned load goes out as one request. A load that straddles a cache line goes out as two requests, low half first and high half second. Both halves share one tracking record. Each record counts the halves that are still outstanding, holds the byte buffer that the responses fill, and remembers the load's tag. When the last expected response arrives, the block reports the load complete, together with its merged bytes.

The cache may refuse a send attempt. Each refusal hands the load back to a replay queue through a one-cycle blocked pulse that carries the load's tag. No fault is raised. The record is handled in one of two ways:

- **Low half (or whole load) refused.** Nothing was ever sent for this record, so it is released at once.
- **High half refused after the low half was accepted.** The record stays alive, marked stale, with one fewer half outstanding. When the low half's response later arrives, it is thrown away and the record is released. No completion is reported.

A new load is accepted only while the issuer is idle and a free record exists. Each request carries its record number, and the matching response returns that number. The record table is small, so stalling the load input when it is full is the normal way back-pressure reaches the pipeline.

Top module: `lsu_split_issuer`

## Requirements
- R1: A non-split load produces exactly one request with the half flag low, in the cycle after it is accepted. A response on that request's record ID raises the completion output in the cycle after the response, with the load's tag and all response bytes.
- R2: A split load produces a low-half request (half flag 0). If that request is accepted, a high-half request (half flag 1) follows in the next cycle with the same record ID.
- R3: If a low-half or non-split request is refused, no high-half request follows. The blocked output pulses for one cycle in the next cycle, carrying the load's tag. The record is freed, and a later response on its ID raises no completion.
- R4: If a high-half request is refused after its low half was accepted, the blocked output pulses in the next cycle with the load's tag. The later low-half response raises no completion and frees the record. This holds even when that response arrives in the same cycle as the refusal.
- R5: A split load completes only after both of its responses have arrived, in either order. The first response alone raises no completion.
- R6: In the completed data of a split load, byte b comes from byte b of the low-half response when b is below the low-half size. Otherwise it comes from byte b minus the low-half size of the high-half response.
- R7: The load-ready output is low while every record is in use and rises in the cycle after a completing response frees one.
- R8: After reset, load-ready is high, and the request, blocked and completion outputs are low.
- R9: The record ID on each request is that of a record not in use when the load was accepted, and records are taken lowest free number first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is offered |
| ld_ready | output | 1 | Issuer idle and a record is free |
| ld_tag | input | TAG_W | Load identifier |
| ld_split | input | 1 | Load crosses a line and needs two halves |
| ld_lo_size | input | SZ_W | Byte count of the low half (split loads) |
| req_valid | output | 1 | A send attempt is made this cycle |
| req_ready | input | 1 | Cache accepts the attempt this cycle |
| req_id | output | ID_W | Record ID travelling with the request |
| req_hi | output | 1 | 1 for the high half, 0 for the low half or a whole load |
| rsp_valid | input | 1 | A cache response is present |
| rsp_id | input | ID_W | Record ID returned with the response |
| rsp_hi | input | 1 | Response belongs to the high half |
| rsp_data | input | BUF_BYTES*8 | Response bytes, byte 0 in the low bits |
| blk_valid | output | 1 | One-cycle blocked report to the replay queue |
| blk_tag | output | TAG_W | Tag of the blocked load |
| cmp_valid | output | 1 | One-cycle completion pulse |
| cmp_tag | output | TAG_W | Tag of the completed load |
| cmp_data | output | BUF_BYTES*8 | Merged load bytes |

## Verification
The hardest case to reach from the ports is a stale record. The low half must be accepted, the high half refused one cycle later, and the low response must come back either in that same refusal cycle or afterwards. The directed tasks hold req_ready high for exactly the low-half cycle and drop it for the high-half cycle. One task drives the low response in the very cycle of the refusal. Whether each stale record is really freed is proven afterwards by filling the whole table with new loads and watching load-ready fall only when all records are taken.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

    // Issue sequencer states: idle, trying low half (or whole load), trying high half
    typedef enum logic [1:0] {
        IS_IDLE = 2'd0,
        IS_LO   = 2'd1,
        IS_HI   = 2'd2
    } iss_state_e;

endpackage

// File: rtl/lsu_split_rec_table.sv
module lsu_split_rec_table #(
    parameter int NREC      = 4,
    parameter int TAG_W     = 6,
    parameter int BUF_BYTES = 8,
    parameter int ID_W      = $clog2(NREC),
    parameter int SZ_W      = $clog2(BUF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_i,
    input  logic [ID_W-1:0]        alloc_id_i,
    input  logic [TAG_W-1:0]       alloc_tag_i,
    input  logic                   alloc_split_i,
    input  logic [SZ_W-1:0]        alloc_lo_size_i,
    input  logic                   drop_i,
    input  logic [ID_W-1:0]        drop_id_i,
    input  logic                   stale_i,
    input  logic [ID_W-1:0]        stale_id_i,
    input  logic                   rsp_valid_i,
    input  logic [ID_W-1:0]        rsp_id_i,
    input  logic                   rsp_hi_i,
    input  logic [BUF_BYTES*8-1:0] rsp_data_i,
    output logic                   free_vld_o,
    output logic [ID_W-1:0]        free_id_o,
    output logic                   cmp_valid_o,
    output logic [TAG_W-1:0]       cmp_tag_o,
    output logic [BUF_BYTES*8-1:0] cmp_data_o
);

    localparam int BUF_W = BUF_BYTES * 8;

    typedef struct packed {
        logic             busy;
        logic             split;
        logic             stale;
        logic [1:0]       cnt;
        logic [TAG_W-1:0] tag;
        logic [SZ_W-1:0]  lo_size;
        logic [BUF_W-1:0] data;
    } rec_t;

    typedef struct packed {
        rec_t [NREC-1:0]  rec;
        logic             cmp_v;
        logic [TAG_W-1:0] cmp_tag;
        logic [BUF_W-1:0] cmp_data;
    } tbl_t;

    tbl_t             tbl_d, tbl_q;
    rec_t             cur;
    logic             hit;
    logic [BUF_W-1:0] merged;

    // Lowest-numbered free record
    always_comb begin
        free_vld_o = 1'b0;
        free_id_o  = '0;
        for (int i = NREC - 1; i >= 0; i--) begin
            if (!tbl_q.rec[i].busy) begin
                free_vld_o = 1'b1;
                free_id_o  = ID_W'(i);
            end
        end
    end

    always_comb begin
        tbl_d       = tbl_q;
        tbl_d.cmp_v = 1'b0;

        if (alloc_i) begin
            tbl_d.rec[alloc_id_i].busy    = 1'b1;
            tbl_d.rec[alloc_id_i].split   = alloc_split_i;
            tbl_d.rec[alloc_id_i].stale   = 1'b0;
            tbl_d.rec[alloc_id_i].cnt     = alloc_split_i ? 2'd2 : 2'd1;
            tbl_d.rec[alloc_id_i].tag     = alloc_tag_i;
            tbl_d.rec[alloc_id_i].lo_size = alloc_lo_size_i;
            tbl_d.rec[alloc_id_i].data    = '0;
        end

        // Nothing went out: release immediately
        if (drop_i) begin
            tbl_d.rec[drop_id_i].busy = 1'b0;
        end

        // High half refused after low half went out: keep record, mark stale
        if (stale_i) begin
            tbl_d.rec[stale_id_i].cnt   = tbl_d.rec[stale_id_i].cnt - 2'd1;
            tbl_d.rec[stale_id_i].stale = 1'b1;
        end

        // Responses only count against records that were live before this edge
        hit    = rsp_valid_i && tbl_q.rec[rsp_id_i].busy;
        cur    = tbl_d.rec[rsp_id_i];
        merged = cur.data;
        for (int b = 0; b < BUF_BYTES; b++) begin
            if (!rsp_hi_i) begin
                if (!cur.split || b < int'(cur.lo_size)) begin
                    merged[b*8 +: 8] = rsp_data_i[b*8 +: 8];
                end
            end else if (b >= int'(cur.lo_size)) begin
                merged[b*8 +: 8] = rsp_data_i[(b - int'(cur.lo_size))*8 +: 8];
            end
        end

        if (hit) begin
            if (cur.stale) begin
                tbl_d.rec[rsp_id_i].busy = 1'b0;
            end else begin
                tbl_d.rec[rsp_id_i].data = merged;
                tbl_d.rec[rsp_id_i].cnt  = cur.cnt - 2'd1;
                if (cur.cnt == 2'd1) begin
                    tbl_d.rec[rsp_id_i].busy = 1'b0;
                    tbl_d.cmp_v              = 1'b1;
                    tbl_d.cmp_tag            = cur.tag;
                    tbl_d.cmp_data           = merged;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign cmp_valid_o = tbl_q.cmp_v;
    assign cmp_tag_o   = tbl_q.cmp_tag;
    assign cmp_data_o  = tbl_q.cmp_data;

    AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !tbl_q.rec[alloc_id_i].busy) else $error("alloc into busy record"); // R7
    AST_CMP_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid_o |-> $past(rsp_valid_i)) else $error("completion without response"); // R5
    AST_STALE_ON_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        stale_i |-> (tbl_q.rec[stale_id_i].busy && tbl_q.rec[stale_id_i].split)) else $error("stale mark on dead record"); // R4

endmodule

// File: rtl/lsu_split_issue_fsm.sv
module lsu_split_issue_fsm
    import lsu_split_pkg::*;
#(
    parameter int NREC  = 4,
    parameter int TAG_W = 6,
    parameter int ID_W  = $clog2(NREC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid_i,
    input  logic [TAG_W-1:0] ld_tag_i,
    input  logic             ld_split_i,
    output logic             ld_ready_o,
    input  logic             free_vld_i,
    input  logic [ID_W-1:0]  free_id_i,
    output logic             alloc_o,
    output logic             req_valid_o,
    input  logic             req_ready_i,
    output logic [ID_W-1:0]  req_id_o,
    output logic             req_hi_o,
    output logic             drop_o,
    output logic             stale_o,
    output logic [ID_W-1:0]  rec_id_o,
    output logic             blk_valid_o,
    output logic [TAG_W-1:0] blk_tag_o
);

    typedef struct packed {
        iss_state_e       state;
        logic [ID_W-1:0]  id;
        logic [TAG_W-1:0] tag;
        logic             split;
        logic             blk_v;
        logic [TAG_W-1:0] blk_tag;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        ld_ready_o  = (seq_q.state == IS_IDLE) && free_vld_i;
        alloc_o     = ld_valid_i && ld_ready_o;
        req_valid_o = (seq_q.state != IS_IDLE);
        req_hi_o    = (seq_q.state == IS_HI);
        req_id_o    = seq_q.id;
        rec_id_o    = seq_q.id;
        drop_o      = (seq_q.state == IS_LO) && !req_ready_i;
        stale_o     = (seq_q.state == IS_HI) && !req_ready_i;

        seq_d       = seq_q;
        seq_d.blk_v = 1'b0;
        unique case (seq_q.state)
            IS_IDLE: begin
                if (alloc_o) begin
                    seq_d.state = IS_LO;
                    seq_d.id    = free_id_i;
                    seq_d.tag   = ld_tag_i;
                    seq_d.split = ld_split_i;
                end
            end
            IS_LO: begin
                if (req_ready_i) begin
                    seq_d.state = seq_q.split ? IS_HI : IS_IDLE;
                end else begin
                    seq_d.state   = IS_IDLE;
                    seq_d.blk_v   = 1'b1;
                    seq_d.blk_tag = seq_q.tag;
                end
            end
            IS_HI: begin
                seq_d.state = IS_IDLE;
                if (!req_ready_i) begin
                    seq_d.blk_v   = 1'b1;
                    seq_d.blk_tag = seq_q.tag;
                end
            end
            default: seq_d.state = IS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign blk_valid_o = seq_q.blk_v;
    assign blk_tag_o   = seq_q.blk_tag;

    AST_HI_AFTER_LO_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_hi_o) |-> $past(req_valid_o && !req_hi_o && req_ready_i)) else $error("high half without accepted low"); // R2
    AST_NO_HI_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_hi_o && !req_ready_i) |=> !(req_valid_o && req_hi_o)) else $error("high half after refused low"); // R3
    AST_BLK_FROM_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid_o |-> $past(req_valid_o && !req_ready_i)) else $error("blocked report without refusal"); // R4
    AST_HI_SAME_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_hi_o) |-> (req_id_o == $past(req_id_o))) else $error("high half changed id"); // R2

endmodule

// File: rtl/lsu_split_issuer.sv
module lsu_split_issuer #(
    parameter int NREC      = 4,
    parameter int TAG_W     = 6,
    parameter int BUF_BYTES = 8,
    parameter int ID_W      = $clog2(NREC),
    parameter int SZ_W      = $clog2(BUF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_valid,
    output logic                   ld_ready,
    input  logic [TAG_W-1:0]       ld_tag,
    input  logic                   ld_split,
    input  logic [SZ_W-1:0]        ld_lo_size,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [ID_W-1:0]        req_id,
    output logic                   req_hi,
    input  logic                   rsp_valid,
    input  logic [ID_W-1:0]        rsp_id,
    input  logic                   rsp_hi,
    input  logic [BUF_BYTES*8-1:0] rsp_data,
    output logic                   blk_valid,
    output logic [TAG_W-1:0]       blk_tag,
    output logic                   cmp_valid,
    output logic [TAG_W-1:0]       cmp_tag,
    output logic [BUF_BYTES*8-1:0] cmp_data
);

    logic            free_vld;
    logic [ID_W-1:0] free_id;
    logic            alloc;
    logic            drop;
    logic            stale;
    logic [ID_W-1:0] rec_id;

    lsu_split_issue_fsm #(
        .NREC  (NREC),
        .TAG_W (TAG_W),
        .ID_W  (ID_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid_i  (ld_valid),
        .ld_tag_i    (ld_tag),
        .ld_split_i  (ld_split),
        .ld_ready_o  (ld_ready),
        .free_vld_i  (free_vld),
        .free_id_i   (free_id),
        .alloc_o     (alloc),
        .req_valid_o (req_valid),
        .req_ready_i (req_ready),
        .req_id_o    (req_id),
        .req_hi_o    (req_hi),
        .drop_o      (drop),
        .stale_o     (stale),
        .rec_id_o    (rec_id),
        .blk_valid_o (blk_valid),
        .blk_tag_o   (blk_tag)
    );

    lsu_split_rec_table #(
        .NREC      (NREC),
        .TAG_W     (TAG_W),
        .BUF_BYTES (BUF_BYTES),
        .ID_W      (ID_W),
        .SZ_W      (SZ_W)
    ) u_tbl (
        .clk             (clk),
        .rst_n           (rst_n),
        .alloc_i         (alloc),
        .alloc_id_i      (free_id),
        .alloc_tag_i     (ld_tag),
        .alloc_split_i   (ld_split),
        .alloc_lo_size_i (ld_lo_size),
        .drop_i          (drop),
        .drop_id_i       (rec_id),
        .stale_i         (stale),
        .stale_id_i      (rec_id),
        .rsp_valid_i     (rsp_valid),
        .rsp_id_i        (rsp_id),
        .rsp_hi_i        (rsp_hi),
        .rsp_data_i      (rsp_data),
        .free_vld_o      (free_vld),
        .free_id_o       (free_id),
        .cmp_valid_o     (cmp_valid),
        .cmp_tag_o       (cmp_tag),
        .cmp_data_o      (cmp_data)
    );

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ld_valid) |-> !ld_ready) else $error("load accepted mid-issue"); // R7

endmodule

// File: tb/lsu_split_issuer_bench.sv
module lsu_split_issuer_bench;

    localparam int NREC      = 4;
    localparam int TAG_W     = 6;
    localparam int BUF_BYTES = 8;
    localparam int ID_W      = $clog2(NREC);
    localparam int SZ_W      = $clog2(BUF_BYTES + 1);
    localparam int BW        = BUF_BYTES * 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ld_valid, ld_ready, ld_split;
    logic [TAG_W-1:0] ld_tag;
    logic [SZ_W-1:0]  ld_lo_size;
    logic             req_valid, req_ready, req_hi;
    logic [ID_W-1:0]  req_id;
    logic             rsp_valid, rsp_hi;
    logic [ID_W-1:0]  rsp_id;
    logic [BW-1:0]    rsp_data;
    logic             blk_valid, cmp_valid;
    logic [TAG_W-1:0] blk_tag, cmp_tag;
    logic [BW-1:0]    cmp_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lsu_split_issuer u_lsu_split_issuer (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_tag(ld_tag),
        .ld_split(ld_split), .ld_lo_size(ld_lo_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_hi(req_hi),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_hi(rsp_hi), .rsp_data(rsp_data),
        .blk_valid(blk_valid), .blk_tag(blk_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data)
    );

    task automatic chk(input string rq, input string what, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] merge_exp(input logic [BW-1:0] lo, input logic [BW-1:0] hi, input int los);
        logic [BW-1:0] r;
        r = '0;
        for (int b = 0; b < BUF_BYTES; b++) begin
            if (b < los) r[b*8 +: 8] = lo[b*8 +: 8];
            else         r[b*8 +: 8] = hi[(b-los)*8 +: 8];
        end
        return r;
    endfunction

    // Offer a load at a negedge; returns at the next negedge with the first attempt visible
    task automatic offer(input logic [TAG_W-1:0] tag, input logic split, input int los);
        @(negedge clk);
        ld_valid   = 1'b1;
        ld_tag     = tag;
        ld_split   = split;
        ld_lo_size = SZ_W'(los);
        chk("R7", "ld_ready when a record is free", BW'(ld_ready), BW'(1));
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic respond(input logic [ID_W-1:0] id, input logic hi, input logic [BW-1:0] d);
        rsp_valid = 1'b1;
        rsp_id    = id;
        rsp_hi    = hi;
        rsp_data  = d;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R8", "ld_ready after reset", BW'(ld_ready), BW'(1));
        chk("R8", "req_valid after reset", BW'(req_valid), BW'(0));
        chk("R8", "blk_valid after reset", BW'(blk_valid), BW'(0));
        chk("R8", "cmp_valid after reset", BW'(cmp_valid), BW'(0));
    endtask

    task automatic t_plain;
        logic [ID_W-1:0] id;
        logic [BW-1:0]   d = 64'h8877_6655_4433_2211;
        offer(6'h05, 1'b0, 0);
        chk("R1", "single request valid", BW'(req_valid), BW'(1));
        chk("R1", "single request is low", BW'(req_hi), BW'(0));
        chk("R9", "first record is lowest", BW'(req_id), BW'(0));
        id = req_id;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R1", "no second request", BW'(req_valid), BW'(0));
        respond(id, 1'b0, d);
        chk("R1", "completion pulse", BW'(cmp_valid), BW'(1));
        chk("R1", "completion tag", BW'(cmp_tag), BW'(6'h05));
        chk("R1", "completion data", cmp_data, d);
        @(negedge clk);
        chk("R1", "completion one cycle", BW'(cmp_valid), BW'(0));
    endtask

    task automatic t_split(input int los, input bit hi_first);
        logic [ID_W-1:0] id;
        logic [BW-1:0]   dl = 64'hA7A6_A5A4_A3A2_A1A0;
        logic [BW-1:0]   dh = 64'hB7B6_B5B4_B3B2_B1B0;
        offer(6'h09, 1'b1, los);
        chk("R2", "low half first", BW'(req_hi), BW'(0));
        id = req_id;
        req_ready = 1'b1;
        @(negedge clk);
        chk("R2", "high half attempted", BW'(req_valid && req_hi), BW'(1));
        chk("R2", "high half same id", BW'(req_id), BW'(id));
        @(negedge clk);
        req_ready = 1'b0;
        respond(id, hi_first, hi_first ? dh : dl);
        chk("R5", "no completion after one half", BW'(cmp_valid), BW'(0));
        respond(id, !hi_first, hi_first ? dl : dh);
        chk("R5", "completion after both halves", BW'(cmp_valid), BW'(1));
        chk("R5", "split completion tag", BW'(cmp_tag), BW'(6'h09));
        chk("R6", "merged data", cmp_data, merge_exp(dl, dh, los));
    endtask

    task automatic t_lo_refused;
        logic [ID_W-1:0] id;
        offer(6'h0A, 1'b1, 3);
        id = req_id;
        req_ready = 1'b0;
        @(negedge clk);
        chk("R3", "no high half after refusal", BW'(req_valid), BW'(0));
        chk("R3", "blocked pulse", BW'(blk_valid), BW'(1));
        chk("R3", "blocked tag", BW'(blk_tag), BW'(6'h0A));
        @(negedge clk);
        chk("R3", "blocked one cycle", BW'(blk_valid), BW'(0));
        respond(id, 1'b0, '1);
        chk("R3", "response to freed record ignored", BW'(cmp_valid), BW'(0));
    endtask

    task automatic t_hi_refused(input bit rsp_same_cycle);
        logic [ID_W-1:0] id;
        offer(6'h0B, 1'b1, 4);
        id = req_id;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (rsp_same_cycle) begin
            respond(id, 1'b0, 64'h1234);
            chk("R4", "blocked pulse with same-cycle response", BW'(blk_valid), BW'(1));
            chk("R4", "stale response raises no completion", BW'(cmp_valid), BW'(0));
            @(negedge clk);
            chk("R4", "still no completion", BW'(cmp_valid), BW'(0));
        end else begin
            @(negedge clk);
            chk("R4", "blocked pulse", BW'(blk_valid), BW'(1));
            chk("R4", "blocked tag", BW'(blk_tag), BW'(6'h0B));
            respond(id, 1'b0, 64'h5678);
            chk("R4", "stale response raises no completion", BW'(cmp_valid), BW'(0));
        end
    endtask

    task automatic t_full;
        logic [ID_W-1:0] ids [NREC];
        for (int i = 0; i < NREC; i++) begin
            offer(TAG_W'(6'h20 + i), 1'b0, 0);
            chk("R9", "lowest free record taken", BW'(req_id), BW'(i));
            ids[i] = req_id;
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
        end
        chk("R7", "ld_ready low when full", BW'(ld_ready), BW'(0));
        respond(ids[2], 1'b0, 64'h22);
        chk("R7", "completion frees record", BW'(cmp_tag), BW'(6'h22));
        chk("R7", "ld_ready back after free", BW'(ld_ready), BW'(1));
        for (int i = 0; i < NREC; i++) begin
            if (i != 2) begin
                respond(ids[i], 1'b0, BW'(i));
                chk("R1", "drain completion tag", BW'(cmp_tag), BW'(6'h20 + i));
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; ld_valid = 1'b0; ld_tag = '0; ld_split = 1'b0; ld_lo_size = '0;
        req_ready = 1'b0; rsp_valid = 1'b0; rsp_id = '0; rsp_hi = 1'b0; rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_split(3, 1'b0);
        t_split(5, 1'b1);
        t_split(1, 1'b0);
        t_lo_refused();
        t_hi_refused(1'b0);
        t_hi_refused(1'b1);
        t_full();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule